// File: doc/BRIEF.md
# Floating-Point Condition Branch Evaluator

This block decides whether a floating-point conditional branch is taken. It keeps a 2-bit condition code that records the outcome of the most recent floating-point compare. The compare datapath is outside the block: it delivers an outcome code and two NaN flags on a write port. The branch side presents the 4-bit condition field, the annul bit, the 22-bit word displacement and the program counter of a branch. One cycle later the block returns the taken decision, the target address and whether the delay slot is annulled.

A compare can be plain or signaling. A signaling compare with a NaN operand raises a one-cycle exception pulse, and its result is dropped so that the trap handler still sees the old code. A branch always tests the registered code. A compare that arrives in the same cycle as a branch is therefore seen only by later branches.

Top module: `fcond_branch_unit`

## Requirements
- R1: After reset the condition code holds equal, and `res_valid`, `res_taken`, `res_annul_slot`, `fp_exception` are 0 and `res_target` is 0.
- R2: The outcome code is eq=0, lt=1, gt=2, un=3. When `cmp_valid` is high, an accepted compare stores `cmp_outcome` in the condition code at that clock edge.
- R3: Condition field encoding and accepted outcomes: 0 never {}, 1 NE {lt,gt,un}, 2 LG {lt,gt}, 3 UL {lt,un}, 4 L {lt}, 5 UG {gt,un}, 6 G {gt}, 7 U {un}, 8 always {all}, 9 E {eq}, 10 UE {eq,un}, 11 GE {eq,gt}, 12 UGE {eq,gt,un}, 13 LE {eq,lt}, 14 ULE {eq,lt,un}, 15 O {eq,lt,gt}. The branch is taken when the stored code is in the set.
- R4: Codes 8 (always) and 0 (never) are unconditional. Always is taken and never is not taken, whatever the stored code.
- R5: For an unconditional branch, `res_annul_slot` equals the annul bit. For a conditional branch, the slot is annulled only when the annul bit is set and the branch is not taken.
- R6: `res_target` = `br_pc` + (sign-extended `br_disp` shifted left by 2), taken modulo 2^32.
- R7: A signaling compare (`cmp_signaling`=1) with `cmp_nan_a` or `cmp_nan_b` set drives `fp_exception` high for exactly the next cycle. A plain compare never raises it, even with a NaN operand.
- R8: A signaling compare that raises the exception leaves the condition code unchanged.
- R9: A branch tests the code registered before its cycle. A compare written in the same cycle is not visible to that branch, but it is visible to the following one.
- R10: Results appear one cycle after `br_valid`. In a cycle that follows no branch, `res_valid`, `res_taken` and `res_annul_slot` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare result write strobe |
| cmp_outcome | input | 2 | Compare outcome: eq=0, lt=1, gt=2, un=3 |
| cmp_signaling | input | 1 | Compare is the signaling variant |
| cmp_nan_a | input | 1 | First operand is a NaN |
| cmp_nan_b | input | 1 | Second operand is a NaN |
| br_valid | input | 1 | Branch evaluation request |
| br_cond | input | 4 | Branch condition field |
| br_annul | input | 1 | Branch annul bit |
| br_disp | input | 22 | Signed word displacement |
| br_pc | input | 32 | Address of the branch |
| res_valid | output | 1 | Branch result valid |
| res_taken | output | 1 | Branch taken |
| res_target | output | 32 | Branch target address |
| res_annul_slot | output | 1 | Delay slot is annulled |
| fp_exception | output | 1 | Signaling compare saw a NaN |

## Verification
A compare write and a branch evaluation can fall in the same cycle. The bench provokes this by driving a compare that changes the code and a branch whose condition separates the old code from the new one in the same cycle. It judges the result by checking that this branch follows the old code and that the next branch follows the new one. A trapped signaling compare is also placed between branches to show that the code survives it.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_e;

    localparam logic [3:0] COND_NEVER  = 4'h0;
    localparam logic [3:0] COND_ALWAYS = 4'h8;
    localparam logic [3:0] COND_ORD    = 4'hF;

    // Accepted-outcome mask, bit index = outcome code (eq, lt, gt, un).
    // The upper half of the condition space is the complement of the lower.
    function automatic logic [3:0] cond_mask(input logic [3:0] cond);
        logic [3:0] base;
        case (cond[2:0])
            3'd0:    base = 4'b0000; // never
            3'd1:    base = 4'b1110; // lt gt un
            3'd2:    base = 4'b0110; // lt gt
            3'd3:    base = 4'b1010; // lt un
            3'd4:    base = 4'b0010; // lt
            3'd5:    base = 4'b1100; // gt un
            3'd6:    base = 4'b0100; // gt
            default: base = 4'b1000; // un
        endcase
        return base ^ {4{cond[3]}};
    endfunction

endpackage

// File: rtl/fbr_cond_eval.sv
module fbr_cond_eval
    import fbr_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [1:0] fcc,
    output logic       hit,
    output logic       uncond
);
    logic [3:0] mask;

    always_comb begin
        mask   = cond_mask(cond);
        hit    = mask[fcc];
        uncond = (cond[2:0] == 3'd0);
    end
endmodule

// File: rtl/fbr_target_gen.sv
module fbr_target_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 22
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] offset;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
        end else begin : g_trunc
            assign offset = ADDR_W'({disp, 2'b00});
        end
    endgenerate

    assign target = pc + offset;
endmodule

// File: rtl/fcond_branch_unit.sv
module fcond_branch_unit
    import fbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_outcome,
    input  logic              cmp_signaling,
    input  logic              cmp_nan_a,
    input  logic              cmp_nan_b,
    input  logic              br_valid,
    input  logic [3:0]        br_cond,
    input  logic              br_annul,
    input  logic [DISP_W-1:0] br_disp,
    input  logic [ADDR_W-1:0] br_pc,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_target,
    output logic              res_annul_slot,
    output logic              fp_exception
);

    typedef struct packed {
        fcc_e              fcc;
        logic              valid;
        logic              taken;
        logic              annul;
        logic [ADDR_W-1:0] target;
        logic              exc;
    } state_t;

    state_t st_d, st_q;

    logic              hit;
    logic              uncond;
    logic [ADDR_W-1:0] tgt;
    logic              trap;

    fbr_cond_eval u_eval (
        .cond   (br_cond),
        .fcc    (st_q.fcc),
        .hit    (hit),
        .uncond (uncond)
    );

    fbr_target_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_tgt (
        .pc     (br_pc),
        .disp   (br_disp),
        .target (tgt)
    );

    always_comb begin
        st_d   = st_q;
        trap   = cmp_valid && cmp_signaling && (cmp_nan_a || cmp_nan_b);
        st_d.exc = trap;
        if (cmp_valid && !trap) begin
            st_d.fcc = fcc_e'(cmp_outcome);
        end
        st_d.valid  = br_valid;
        st_d.taken  = br_valid && hit;
        st_d.annul  = br_valid && br_annul && (uncond || !hit);
        st_d.target = br_valid ? tgt : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{fcc: FCC_EQ, valid: 1'b0, taken: 1'b0, annul: 1'b0,
                      target: '0, exc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid      = st_q.valid;
    assign res_taken      = st_q.taken;
    assign res_target     = st_q.target;
    assign res_annul_slot = st_q.annul;
    assign fp_exception   = st_q.exc;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!res_taken && !res_annul_slot)); // R10
    AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond == COND_ALWAYS) |=> res_taken); // R4
    AST_NEVER_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond == COND_NEVER) |=> !res_taken); // R4
    AST_NO_ANNUL_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_annul) |=> !res_annul_slot); // R5
    AST_PLAIN_CMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_signaling) |=> !fp_exception); // R7
    AST_TRAP_KEEPS_FCC: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_signaling && (cmp_nan_a || cmp_nan_b)) |=> $stable(st_q.fcc)); // R8
    AST_UNORD_FAILS_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && st_q.fcc == FCC_UN && br_cond == COND_ORD) |=> !res_taken); // R3

endmodule

// File: tb/fcond_branch_unit_test.sv
`timescale 1ns/1ps
module fcond_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_outcome = 2'd0;
    logic        cmp_signaling = 1'b0;
    logic        cmp_nan_a = 1'b0;
    logic        cmp_nan_b = 1'b0;
    logic        br_valid = 1'b0;
    logic [3:0]  br_cond = 4'd0;
    logic        br_annul = 1'b0;
    logic [21:0] br_disp = 22'd0;
    logic [31:0] br_pc = 32'd0;
    logic        res_valid;
    logic        res_taken;
    logic [31:0] res_target;
    logic        res_annul_slot;
    logic        fp_exception;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fcond_branch_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_outcome(cmp_outcome),
        .cmp_signaling(cmp_signaling), .cmp_nan_a(cmp_nan_a), .cmp_nan_b(cmp_nan_b),
        .br_valid(br_valid), .br_cond(br_cond), .br_annul(br_annul),
        .br_disp(br_disp), .br_pc(br_pc),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .res_annul_slot(res_annul_slot), .fp_exception(fp_exception)
    );

    // {outcome[1:0], cond[3:0], annul, disp[21:0], exp_taken, exp_annul}
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {2'd0, 4'd9,  1'b0, 22'h000010, 1'b1, 1'b0},
        {2'd1, 4'd4,  1'b1, 22'h3FFFFF, 1'b1, 1'b0},
        {2'd2, 4'd4,  1'b1, 22'h000100, 1'b0, 1'b1},
        {2'd3, 4'd7,  1'b0, 22'h200000, 1'b1, 1'b0},
        {2'd3, 4'd15, 1'b1, 22'h000004, 1'b0, 1'b1},
        {2'd2, 4'd12, 1'b0, 22'h1FFFFF, 1'b1, 1'b0},
        {2'd1, 4'd12, 1'b1, 22'h000001, 1'b0, 1'b1},
        {2'd0, 4'd8,  1'b1, 22'h000020, 1'b1, 1'b1},
        {2'd3, 4'd0,  1'b1, 22'h000020, 1'b0, 1'b1},
        {2'd3, 4'd0,  1'b0, 22'h3FFFF0, 1'b0, 1'b0},
        {2'd0, 4'd1,  1'b0, 22'h000000, 1'b0, 1'b0},
        {2'd1, 4'd2,  1'b1, 22'h000008, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench model of the accepted-outcome sets (R3, R4).
    function automatic bit model_taken(input logic [3:0] c, input logic [1:0] o);
        bit e, l, g, u;
        e = (o == 2'd0); l = (o == 2'd1); g = (o == 2'd2); u = (o == 2'd3);
        case (c)
            4'd0:  return 1'b0;
            4'd1:  return !e;
            4'd2:  return l || g;
            4'd3:  return u || l;
            4'd4:  return l;
            4'd5:  return u || g;
            4'd6:  return g;
            4'd7:  return u;
            4'd8:  return 1'b1;
            4'd9:  return e;
            4'd10: return u || e;
            4'd11: return g || e;
            4'd12: return !l;
            4'd13: return l || e;
            4'd14: return !g;
            default: return !u;
        endcase
    endfunction

    function automatic logic [31:0] model_target(input logic [31:0] pc, input logic [21:0] d);
        return pc + 32'(signed'({{10{d[21]}}, d}) * 4);
    endfunction

    task automatic do_cmp(input logic [1:0] o, input bit sig, input bit na, input bit nb);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_outcome = o; cmp_signaling = sig;
        cmp_nan_a = na; cmp_nan_b = nb;
        @(negedge clk);
        cmp_valid = 1'b0; cmp_signaling = 1'b0; cmp_nan_a = 1'b0; cmp_nan_b = 1'b0;
    endtask

    task automatic br_drive(input logic [3:0] c, input bit a, input logic [21:0] d,
                            input logic [31:0] pc);
        br_valid = 1'b1; br_cond = c; br_annul = a; br_disp = d; br_pc = pc;
    endtask

    task automatic do_br(input logic [3:0] c, input bit a, input logic [21:0] d,
                         input logic [31:0] pc);
        @(negedge clk);
        br_drive(c, a, d, pc);
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(res_valid == 0 && res_taken == 0 && res_annul_slot == 0 && fp_exception == 0,
            "R1 outputs at reset", {res_valid, res_taken, res_annul_slot, fp_exception}, 0);
        chk(res_target == 0, "R1 target at reset", res_target, 0);
        rst_n = 1'b1;
        do_br(4'd9, 1'b0, 22'd0, 32'h100);
        chk(res_taken == 1, "R1 code resets to equal", res_taken, 1);
        @(negedge clk);
        chk(res_valid == 0 && res_taken == 0, "R10 idle after branch",
            {res_valid, res_taken}, 0);

        // Vector table: R2, R3, R5, R6
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            do_cmp(v[30:29], 1'b0, 1'b0, 1'b0);
            do_br(v[28:25], v[24], v[23:2], 32'h0000_4000);
            chk(res_valid == 1, "R10 valid after branch", res_valid, 1);
            chk(res_taken == v[1], "R3 taken from table", res_taken, v[1]);
            chk(res_annul_slot == v[0], "R5 annul from table", res_annul_slot, v[0]);
            chk(res_target == model_target(32'h0000_4000, v[23:2]), "R6 target",
                res_target, model_target(32'h0000_4000, v[23:2]));
        end

        // Full sweep of outcomes and conditions: R2, R3, R4, R5
        for (int o = 0; o < 4; o++) begin
            do_cmp(2'(o), 1'b0, 1'b0, 1'b0);
            for (int c = 0; c < 16; c++) begin
                bit exp_t, exp_a, a;
                a = c[0] ^ o[0];
                exp_t = model_taken(4'(c), 2'(o));
                exp_a = (c == 0 || c == 8) ? a : (a && !exp_t);
                do_br(4'(c), a, 22'h000003, 32'h0001_0000);
                chk(res_taken == exp_t, "R3 sweep taken", res_taken, exp_t);
                chk(res_annul_slot == exp_a, "R5 sweep annul", res_annul_slot, exp_a);
            end
        end

        // R7 / R8: signaling compare with NaN traps and keeps the code
        do_cmp(2'd2, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_outcome = 2'd3; cmp_signaling = 1'b1; cmp_nan_a = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0; cmp_signaling = 1'b0; cmp_nan_a = 1'b0;
        chk(fp_exception == 1, "R7 signaling NaN raises", fp_exception, 1);
        @(negedge clk);
        chk(fp_exception == 0, "R7 exception lasts one cycle", fp_exception, 0);
        do_br(4'd6, 1'b0, 22'd0, 32'h0);
        chk(res_taken == 1, "R8 trapped compare keeps gt", res_taken, 1);
        do_cmp(2'd3, 1'b1, 1'b0, 1'b1);
        chk(fp_exception == 1, "R7 second operand NaN raises", fp_exception, 1);
        do_br(4'd7, 1'b0, 22'd0, 32'h0);
        chk(res_taken == 0, "R8 code not set unordered", res_taken, 0);
        do_cmp(2'd3, 1'b0, 1'b1, 1'b1);
        chk(fp_exception == 0, "R7 plain compare silent", fp_exception, 0);
        do_br(4'd7, 1'b0, 22'd0, 32'h0);
        chk(res_taken == 1, "R2 plain compare stores un", res_taken, 1);
        do_cmp(2'd1, 1'b1, 1'b0, 1'b0);
        chk(fp_exception == 0, "R7 signaling without NaN silent", fp_exception, 0);
        do_br(4'd4, 1'b0, 22'd0, 32'h0);
        chk(res_taken == 1, "R2 signaling ordered compare stores lt", res_taken, 1);

        // R9: compare and branch in the same cycle
        do_cmp(2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_outcome = 2'd1;
        br_drive(4'd9, 1'b1, 22'd0, 32'h0);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(res_taken == 1, "R9 same-cycle branch sees old eq", res_taken, 1);
        chk(res_annul_slot == 0, "R9 same-cycle annul from old code", res_annul_slot, 0);
        br_drive(4'd4, 1'b1, 22'd0, 32'h0);
        @(negedge clk);
        br_valid = 1'b0;
        chk(res_taken == 1, "R9 next branch sees new lt", res_taken, 1);
        @(negedge clk);
        chk(res_valid == 0 && res_annul_slot == 0, "R10 quiet without branch",
            {res_valid, res_annul_slot}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule